// File: doc/BRIEF.md
# UART Interrupt Status Controller

This block gathers fourteen single-cycle event pulses produced elsewhere in a UART and records each one in a sticky status bit. A parallel enable register, with the same bit layout, decides which recorded events may raise the interrupt line. Software reads the status word, acts on it, then writes that same word back to acknowledge precisely the bits it has handled. Writing a one clears a bit and writing a zero leaves it alone.

A status bit is recorded whether or not it is enabled, so a handler may also poll for it. The interrupt line is an active-high level. It follows the enabled, pending status one clock later. Two further level outputs give the same summary for the receive group and for the transmit group of events, so a handler can pick which service routine to run first.

Register access goes through a single-cycle write strobe with address and data. Read data is a combinational function of the address.

Top module: `ist_ctrl`

## Requirements
- R1: After reset the status word, the enable word and the `irq`, `rx_irq` and `tx_irq` outputs are all zero.
- R2: A one on bit i of `evt_i` at a clock edge sets status bit i at that edge, whatever the enable bit i holds. The bit then stays set until it is cleared.
- R3: A write to address 0 (status) clears every status bit whose `wdata` bit is one. Status bits whose `wdata` bit is zero are unchanged.
- R4: When an event pulse and a write-one clear reach the same status bit at the same edge, the bit ends up set.
- R5: A write to address 1 (enable) loads `wdata[13:0]` into the enable word. Reading address 1 returns the enable word, and `rdata` bits 15:14 read as zero.
- R6: `irq` is high in the cycle after an edge exactly when, before that edge, at least one status bit was set with its enable bit also set.
- R7: `rx_irq` follows the rule of R6 restricted to status bits 4, 5, 7, 8, 9 and 11 (RX almost full, RX full, RX overrun, parity error, framing error, RX timeout). `tx_irq` follows it restricted to bits 2, 3 and 6 (TX almost empty, TX empty, TX underrun).
- R8: Reading address 0 returns the status word with bits 15:14 zero. Any address other than 0 or 1 reads as zero, and a write to such an address changes neither register.
- R9: A write to the enable register leaves the status word unchanged, and a write to the status register leaves the enable word unchanged.
- R10: The status bit map is fixed: 0 TX data empty, 1 RX data full, 2 TX almost empty, 3 TX empty, 4 RX almost full, 5 RX full, 6 TX underrun, 7 RX overrun, 8 parity error, 9 framing error, 10 CTS change, 11 RX timeout, 12 break done, 13 bus error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_i | input | 14 | Event pulses, one per status bit |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address: 0 status, 1 enable |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| irq | output | 1 | Interrupt level, any enabled status bit set |
| rx_irq | output | 1 | Interrupt level for the receive group |
| tx_irq | output | 1 | Interrupt level for the transmit group |

## Verification
Status and enable change at the edge that samples an event or a write, so `rdata` shows the new value in the following cycle, with no further delay. The three interrupt outputs lag the registers by one more edge. They reflect the status and enable words as they stood before that edge. The bench drives inputs on the falling edge and checks the interrupt outputs there against a model stepped at each rising edge, so the model's registered copies carry that one-cycle lag. It compares `rdata` one nanosecond after driving the address, against the model state left by the previous rising edge.

// File: rtl/ist_pkg.sv
package ist_pkg;
  localparam int NUM_SRC = 14;

  localparam int B_TX_DATA_EMPTY = 0;
  localparam int B_RX_DATA_FULL  = 1;
  localparam int B_TXF_ALMOST    = 2;
  localparam int B_TXF_EMPTY     = 3;
  localparam int B_RXF_ALMOST    = 4;
  localparam int B_RXF_FULL      = 5;
  localparam int B_TX_UNDERRUN   = 6;
  localparam int B_RX_OVERRUN    = 7;
  localparam int B_PARITY_ERR    = 8;
  localparam int B_FRAME_ERR     = 9;
  localparam int B_CTS_CHANGE    = 10;
  localparam int B_RX_TIMEOUT    = 11;
  localparam int B_BREAK_DONE    = 12;
  localparam int B_BUS_ERR       = 13;

  typedef logic [NUM_SRC-1:0] src_vec_t;

  localparam src_vec_t RX_GROUP = src_vec_t'((1 << B_RXF_ALMOST) | (1 << B_RXF_FULL) |
                                             (1 << B_RX_OVERRUN) | (1 << B_PARITY_ERR) |
                                             (1 << B_FRAME_ERR)  | (1 << B_RX_TIMEOUT));
  localparam src_vec_t TX_GROUP = src_vec_t'((1 << B_TXF_ALMOST) | (1 << B_TXF_EMPTY) |
                                             (1 << B_TX_UNDERRUN));
  localparam src_vec_t ALL_GROUP = '1;

  // Next value of a sticky write-one-clear bank; a new event outranks a clear.
  function automatic src_vec_t sticky_next(src_vec_t cur, src_vec_t set, src_vec_t clr);
    return (cur & ~clr) | set;
  endfunction

  // Pending test for one group of sources.
  function automatic logic group_pending(src_vec_t stat, src_vec_t en, src_vec_t mask);
    return |(stat & en & mask);
  endfunction
endpackage

// File: rtl/ist_status_bank.sv
module ist_status_bank
  import ist_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         stat_q[i] <= 1'b0;
      else if (set_i[i])  stat_q[i] <= 1'b1;
      else if (clr_i[i])  stat_q[i] <= 1'b0;
    end

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> stat_q[i]);
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[i] && !clr_i[i]) |=> stat_q[i]);
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !stat_q[i]);
    p_collide_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && set_i[i]) |=> stat_q[i]);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!stat_q[i] && !set_i[i]) |=> !stat_q[i]);
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/ist_enable_reg.sv
module ist_enable_reg
  import ist_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] en_o
);
  logic [N-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= '0;
    else if (wr_i) en_q <= wdata_i;
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(en_q));
  p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (en_q == $past(wdata_i)));

  assign en_o = en_q;
endmodule

// File: rtl/ist_irq_gen.sv
module ist_irq_gen
  import ist_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stat_i,
  input  logic [N-1:0] en_i,
  output logic         irq_o,
  output logic         rx_irq_o,
  output logic         tx_irq_o
);
  localparam int NGRP = 3;
  localparam src_vec_t GRP_MASK [NGRP] = '{ALL_GROUP, RX_GROUP, TX_GROUP};

  logic [NGRP-1:0] pend_d, pend_q;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign pend_d[g] = group_pending(src_vec_t'(stat_i), src_vec_t'(en_i), GRP_MASK[g]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[g] <= 1'b0;
      else        pend_q[g] <= pend_d[g];
    end
  end

  assign irq_o    = pend_q[0];
  assign rx_irq_o = pend_q[1];
  assign tx_irq_o = pend_q[2];

  p_group_in_any_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_irq_o || tx_irq_o) |-> irq_o);
  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|(stat_i & en_i)));
  p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_i & en_i) == '0 |=> !irq_o);
endmodule

// File: rtl/ist_ctrl.sv
module ist_ctrl
  import ist_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int STAT_ADDR = 0,
  parameter int EN_ADDR   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [13:0]       evt_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              rx_irq,
  output logic              tx_irq
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic         sel_stat, sel_en;
  logic         wr_stat, wr_en_reg;
  src_vec_t     clr_vec, stat_w, en_w;

  assign sel_stat  = (addr == ADDR_W'(STAT_ADDR));
  assign sel_en    = (addr == ADDR_W'(EN_ADDR));
  assign wr_stat   = wr_en && sel_stat;
  assign wr_en_reg = wr_en && sel_en;
  assign clr_vec   = wr_stat ? wdata[NUM_SRC-1:0] : '0;

  ist_status_bank #(.N(NUM_SRC)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_i(evt_i), .clr_i(clr_vec), .stat_o(stat_w)
  );

  ist_enable_reg #(.N(NUM_SRC)) u_en (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_en_reg), .wdata_i(wdata[NUM_SRC-1:0]), .en_o(en_w)
  );

  ist_irq_gen #(.N(NUM_SRC)) u_irq (
    .clk(clk), .rst_n(rst_n), .stat_i(stat_w), .en_i(en_w),
    .irq_o(irq), .rx_irq_o(rx_irq), .tx_irq_o(tx_irq)
  );

  always_comb begin
    if (sel_stat)    rdata = {{PAD_W{1'b0}}, stat_w};
    else if (sel_en) rdata = {{PAD_W{1'b0}}, en_w};
    else             rdata = '0;
  end

  p_status_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_reg && evt_i == '0) |=> $stable(stat_w));
  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sel_stat && !sel_en && evt_i == '0) |=> ($stable(stat_w) && $stable(en_w)));
  p_pad_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:NUM_SRC] == '0);
endmodule

// File: tb/tb_ist_ctrl.sv
module tb_ist_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] evt_i = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq, rx_irq, tx_irq;

  int n_run = 0;
  int n_fail = 0;

  logic [13:0] m_stat = '0, m_en = '0;
  logic        m_irq = 1'b0, m_rx = 1'b0, m_tx = 1'b0;

  localparam logic [13:0] RXM = 14'b00_1011_1011_0000; // bits 4,5,7,8,9,11
  localparam logic [13:0] TXM = 14'b00_0000_0100_1100; // bits 2,3,6

  always #2 clk = ~clk;

  ist_ctrl dut (.clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .addr(addr),
                .wdata(wdata), .rdata(rdata), .irq(irq), .rx_irq(rx_irq), .tx_irq(tx_irq));

  function automatic logic [15:0] exp_read(logic [3:0] a);
    if (a == 4'd0) return {2'b00, m_stat};
    if (a == 4'd1) return {2'b00, m_en};
    return 16'h0000;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_outs();
    chk("R6 irq", {15'd0, irq}, {15'd0, m_irq});
    chk("R7 rx_irq", {15'd0, rx_irq}, {15'd0, m_rx});
    chk("R7 tx_irq", {15'd0, tx_irq}, {15'd0, m_tx});
  endtask

  // Drive at the falling edge, check read data, then step the model at the rising edge.
  task automatic cycle(logic [13:0] e, logic w, logic [3:0] a, logic [15:0] d, string tag);
    logic [13:0] clr;
    check_outs();
    evt_i = e; wr_en = w; addr = a; wdata = d;
    #1;
    chk(tag, rdata, exp_read(a));
    @(posedge clk);
    m_irq = |(m_stat & m_en);
    m_rx  = |(m_stat & m_en & RXM);
    m_tx  = |(m_stat & m_en & TXM);
    clr   = (w && a == 4'd0) ? d[13:0] : 14'd0;
    if (w && a == 4'd1) m_en = d[13:0];
    m_stat = (m_stat & ~clr) | e;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0417));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 status after reset", rdata, 16'h0000);
    addr = 4'd1; #1;
    chk("R1 enable after reset", rdata, 16'h0000);
    chk("R1 irq after reset", {13'd0, irq, rx_irq, tx_irq}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R10: disabled event still recorded (bit 12 break done)
    cycle(14'h1000, 1'b0, 4'd0, 16'h0000, "R2 read before event");
    cycle(14'h0000, 1'b0, 4'd0, 16'h0000, "R2 break bit sticky while disabled");
    cycle(14'h0000, 1'b0, 4'd0, 16'h0000, "R6 irq stays low when disabled");
    // R5: enable write, pad bits read zero
    cycle(14'h0000, 1'b1, 4'd1, 16'hFFFF, "R5 read before enable write");
    cycle(14'h0000, 1'b0, 4'd1, 16'h0000, "R5 enable reads 3FFF");
    cycle(14'h0000, 1'b0, 4'd0, 16'h0000, "R9 status kept by enable write");
    // R7: receive group (parity bit 8) and transmit group (underrun bit 6)
    cycle(14'h0140, 1'b0, 4'd0, 16'h0000, "R7 group events");
    cycle(14'h0000, 1'b0, 4'd0, 16'h0000, "R7 groups pending");
    cycle(14'h0000, 1'b0, 4'd0, 16'h0000, "R7 groups registered");
    // R3: partial clear of bit 6 only
    cycle(14'h0000, 1'b1, 4'd0, 16'h0040, "R3 clear bit 6");
    cycle(14'h0000, 1'b0, 4'd0, 16'h0000, "R3 other bits kept");
    // R4: event and clear collide on bit 3
    cycle(14'h0008, 1'b1, 4'd0, 16'h0008, "R4 collide");
    cycle(14'h0000, 1'b0, 4'd0, 16'h0000, "R4 event wins");
    // R8: unmapped write ignored, unmapped read zero
    cycle(14'h0000, 1'b1, 4'd7, 16'hFFFF, "R8 unmapped read");
    cycle(14'h0000, 1'b0, 4'd0, 16'h0000, "R8 status after unmapped write");
    cycle(14'h0000, 1'b0, 4'd1, 16'h0000, "R8 enable after unmapped write");
    // R9: status write leaves enable alone
    cycle(14'h0000, 1'b1, 4'd0, 16'hFFFF, "R9 clear all");
    cycle(14'h0000, 1'b0, 4'd1, 16'h0000, "R9 enable kept by status write");
    cycle(14'h0000, 1'b0, 4'd0, 16'h0000, "R3 all cleared");
    cycle(14'h0000, 1'b0, 4'd0, 16'h0000, "R6 irq falls after clear");

    // Random phase
    for (int k = 0; k < 3000; k++) begin
      logic [13:0] e;
      logic        w;
      logic [3:0]  a;
      logic [15:0] d;
      string       tag;
      e = 14'($urandom() & $urandom() & $urandom());
      w = ($urandom() % 4) == 0;
      a = 4'($urandom() % 5);
      if (($urandom() % 8) == 0) a = 4'($urandom());
      d = 16'($urandom());
      if (a == 4'd0)      tag = "R2 random status read";
      else if (a == 4'd1) tag = "R5 random enable read";
      else                tag = "R8 random unmapped read";
      cycle(e, w, a, d, tag);
    end
    check_outs();

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule